// File: doc/BRIEF.md
# Multicycle Decimal Accumulator Processor

This block is a small processor built around one accumulator. It runs a program held in an external word-addressed memory of 1000 words. Every instruction word is a signed value limited to five decimal digits. The processor moves through one register transfer per clock. A fetch phase reads the next instruction word through a memory address register and a memory data register, then latches it into the instruction register and advances the program counter. An execute phase of one or three steps follows, depending on the instruction.

The decimal instruction word is split into an operation code (the word divided by 1000) and an operand address (the word modulo 1000). The accumulator A and the auxiliary register B each hold a signed value in the range -99999 to 99999. Multiply and divide treat the pair A:B as a ten-digit quantity. A program stops with a stop instruction. A zero divisor or an undefined code also stops the program, and in that case an error flag is set as well.

The memory seen at the ports reads synchronously. The word at the address on `mem_addr` during a clock edge is on `mem_rdata` after that edge. A write happens at the edge where `mem_we` is high. A test environment loads the program into memory before reset is released.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and after it is released, A reads 0, `halted`, `fault` and `overflow` are low, `mem_we` is low, and the first address presented is 0.
- R2: A word w with 0 <= w <= 99999 decodes to code w/1000 and address w%1000. Fetch spans four clocks. Codes 01, 02, 20, 21, 22 and 23 complete in 7 clocks. Codes 03, 04, 30 and 99 complete in 5 clocks. The program counter stays within 0..999.
- R3: Code 01 copies the addressed word into A. Code 02 writes A to the addressed word.
- R4: Code 20 adds the addressed word to A, and code 21 subtracts it from A. A result outside ±99999 becomes its truncating remainder modulo 100000, with the sign kept, and sets `overflow`. `overflow` stays set until reset, and A never leaves ±99999.
- R5: Code 22 forms A times the addressed word. A receives the product divided by 100000 and B the product modulo 100000, both truncating toward zero.
- R6: Code 23 divides A*100000+B by the addressed word. The truncated quotient goes to A, reduced as in R4 with `overflow` set if it is out of range. The remainder goes to B.
- R7: Code 03 exchanges A and B. Code 04 sets A to 0.
- R8: Code 30 loads the program counter with its address field, so the next fetch comes from that address.
- R9: Code 99 raises `halted` five clocks after its fetch begins. From then on `halted` stays high, A stays constant and no memory write occurs.
- R10: A zero divisor in code 23, an undefined code, or a negative instruction word raises `halted` and `fault` together. A and B keep their previous values in that case.
- R11: `mem_we` is high for exactly one clock per code-02 instruction, in its last step, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 10 | Word address presented to memory |
| mem_wdata | output | 18 | Signed data for a memory write |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 18 | Signed word read from memory, one clock after its address |
| halted | output | 1 | Execution has stopped |
| fault | output | 1 | Stopped because of a zero divisor or an invalid instruction |
| overflow | output | 1 | Sticky flag for an out-of-range decimal result |
| acc_out | output | 18 | Current accumulator value |

## Verification
The assertions check several properties on every cycle. The stopped state is permanent and silent: no writes and a frozen accumulator. The accumulator stays within five decimal digits, and the overflow flag is sticky. Each fault event is followed by both the halted and fault flags, and a write strobe never lasts more than one clock. Only the directed programs in the bench can show that each operation produces the right arithmetic result. The same holds for exact instruction timing in clocks, for decimal wraparound values including negative operands, and for jump targets. The bench reads memory contents after the program stops to confirm the stored A and B values.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  parameter int ADDR_W      = 10;
  parameter int MEM_WORDS   = 1000;
  parameter int VAL_W       = 18;
  parameter int OPC_W       = 8;
  parameter int DIGIT_LIMIT = 99999;
  parameter int HALF_RADIX  = 100000;
  parameter int ADDR_RADIX  = 1000;
  parameter int WIDE_W      = 64;

  typedef logic signed [VAL_W-1:0]  word_t;
  typedef logic [ADDR_W-1:0]        addr_t;
  typedef logic signed [WIDE_W-1:0] wide_t;

  localparam wide_t LIMIT_W = wide_t'(DIGIT_LIMIT);
  localparam wide_t RADIX_W = wide_t'(HALF_RADIX);

  typedef enum logic [OPC_W-1:0] {
    OP_LOAD  = 8'd1,
    OP_STORE = 8'd2,
    OP_SWAP  = 8'd3,
    OP_CLEAR = 8'd4,
    OP_ADD   = 8'd20,
    OP_SUB   = 8'd21,
    OP_MUL   = 8'd22,
    OP_DIV   = 8'd23,
    OP_JUMP  = 8'd30,
    OP_STOP  = 8'd99
  } opc_e;

  typedef enum logic [2:0] {
    ST_FADDR, ST_FREAD, ST_FIR, ST_FINC, ST_X1, ST_X2, ST_X3, ST_HALT
  } step_e;

  typedef struct packed {
    logic  ovf;
    word_t val;
  } fold_t;

  function automatic wide_t widen(input word_t v);
    return wide_t'(v);
  endfunction

  // Reduce to five decimal digits, sign kept, flag when reduction happened.
  function automatic fold_t fold_dec(input wide_t v);
    fold_t r;
    wide_t m;
    if (v > LIMIT_W || v < -LIMIT_W) begin
      m     = v % RADIX_W;
      r.ovf = 1'b1;
    end else begin
      m     = v;
      r.ovf = 1'b0;
    end
    r.val = word_t'(m);
    return r;
  endfunction

  function automatic word_t prod_hi(input word_t a, input word_t m);
    wide_t p;
    p = widen(a) * widen(m);
    return word_t'(p / RADIX_W);
  endfunction

  function automatic word_t prod_lo(input word_t a, input word_t m);
    wide_t p;
    p = widen(a) * widen(m);
    return word_t'(p % RADIX_W);
  endfunction

  function automatic wide_t pair_value(input word_t hi, input word_t lo);
    return widen(hi) * RADIX_W + widen(lo);
  endfunction

  function automatic fold_t pair_quot(input word_t hi, input word_t lo, input word_t m);
    return fold_dec(pair_value(hi, lo) / widen(m));
  endfunction

  function automatic word_t pair_rem(input word_t hi, input word_t lo, input word_t m);
    return word_t'(pair_value(hi, lo) % widen(m));
  endfunction
endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  word_t word_i,
  output opc_e  op_o,
  output addr_t addr_o,
  output logic  legal_o,
  output logic  mem_op_o
);
  localparam int MAG_W = VAL_W - 1;

  logic [MAG_W-1:0] mag;
  logic [OPC_W-1:0] code;
  logic             neg;

  assign neg    = word_i[VAL_W-1];
  assign mag    = word_i[MAG_W-1:0];
  assign code   = OPC_W'(mag / MAG_W'(ADDR_RADIX));
  assign addr_o = ADDR_W'(mag % MAG_W'(ADDR_RADIX));
  assign op_o   = opc_e'(code);

  always_comb begin
    legal_o  = 1'b0;
    mem_op_o = 1'b0;
    case (op_o)
      OP_LOAD, OP_STORE, OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
        legal_o  = !neg;
        mem_op_o = !neg;
      end
      OP_SWAP, OP_CLEAR, OP_JUMP, OP_STOP: legal_o = !neg;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
(
  input  opc_e  op_i,
  input  word_t a_i,
  input  word_t b_i,
  input  word_t m_i,
  output word_t a_o,
  output word_t b_o,
  output logic  ovf_o,
  output logic  div_zero_o
);
  fold_t f;

  always_comb begin
    a_o        = a_i;
    b_o        = b_i;
    ovf_o      = 1'b0;
    div_zero_o = 1'b0;
    f          = '0;
    case (op_i)
      OP_LOAD: a_o = m_i;
      OP_ADD: begin
        f     = fold_dec(widen(a_i) + widen(m_i));
        a_o   = f.val;
        ovf_o = f.ovf;
      end
      OP_SUB: begin
        f     = fold_dec(widen(a_i) - widen(m_i));
        a_o   = f.val;
        ovf_o = f.ovf;
      end
      OP_MUL: begin
        a_o = prod_hi(a_i, m_i);
        b_o = prod_lo(a_i, m_i);
      end
      OP_DIV: begin
        if (m_i == '0) begin
          div_zero_o = 1'b1;
        end else begin
          f     = pair_quot(a_i, b_i, m_i);
          a_o   = f.val;
          b_o   = pair_rem(a_i, b_i, m_i);
          ovf_o = f.ovf;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mem_op_i,
  input  logic  stop_x1_i,
  input  logic  stop_x3_i,
  output step_e step_o
);
  step_e step_q, step_d;

  always_comb begin
    step_d = step_q;
    case (step_q)
      ST_FADDR: step_d = ST_FREAD;
      ST_FREAD: step_d = ST_FIR;
      ST_FIR:   step_d = ST_FINC;
      ST_FINC:  step_d = ST_X1;
      ST_X1: begin
        if (stop_x1_i)     step_d = ST_HALT;
        else if (mem_op_i) step_d = ST_X2;
        else               step_d = ST_FADDR;
      end
      ST_X2:   step_d = ST_X3;
      ST_X3:   step_d = stop_x3_i ? ST_HALT : ST_FADDR;
      ST_HALT: step_d = ST_HALT;
      default: step_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_FADDR;
    else        step_q <= step_d;
  end

  assign step_o = step_q;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int P_ADDR_W    = ADDR_W,
  parameter int P_VAL_W     = VAL_W,
  parameter int P_MEM_WORDS = MEM_WORDS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic [P_ADDR_W-1:0]       mem_addr,
  output logic signed [P_VAL_W-1:0] mem_wdata,
  output logic                      mem_we,
  input  logic signed [P_VAL_W-1:0] mem_rdata,
  output logic                      halted,
  output logic                      fault,
  output logic                      overflow,
  output logic signed [P_VAL_W-1:0] acc_out
);
  localparam addr_t LAST_ADDR = addr_t'(P_MEM_WORDS - 1);

  step_e step;
  addr_t pc_q, mar_q;
  word_t mdr_q, ir_q, a_q, b_q;
  logic  fault_q, ovf_q;

  opc_e  op;
  addr_t op_addr;
  logic  legal, mem_op;

  word_t alu_a, alu_b;
  logic  alu_ovf, div_zero;

  // Named internal events for the checker
  logic stop_x1, stop_x3, fault_evt;

  acc_cpu_decode u_dec (
    .word_i  (ir_q),
    .op_o    (op),
    .addr_o  (op_addr),
    .legal_o (legal),
    .mem_op_o(mem_op)
  );

  acc_cpu_alu u_alu (
    .op_i      (op),
    .a_i       (a_q),
    .b_i       (b_q),
    .m_i       (mdr_q),
    .a_o       (alu_a),
    .b_o       (alu_b),
    .ovf_o     (alu_ovf),
    .div_zero_o(div_zero)
  );

  assign stop_x1   = !legal || (op == OP_STOP);
  assign stop_x3   = div_zero;
  assign fault_evt = ((step == ST_X1) && !legal) || ((step == ST_X3) && div_zero);

  acc_cpu_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_op_i (mem_op),
    .stop_x1_i(stop_x1),
    .stop_x3_i(stop_x3),
    .step_o   (step)
  );

  // Address shown to memory is the value the address register is taking.
  always_comb begin
    case (step)
      ST_FADDR: mem_addr = pc_q;
      ST_X1:    mem_addr = op_addr;
      default:  mem_addr = mar_q;
    endcase
  end

  assign mem_we    = (step == ST_X3) && (op == OP_STORE);
  assign mem_wdata = mdr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      ir_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      fault_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      case (step)
        ST_FADDR: mar_q <= pc_q;
        ST_FREAD: mdr_q <= mem_rdata;
        ST_FIR:   ir_q  <= mdr_q;
        ST_FINC:  pc_q  <= (pc_q == LAST_ADDR) ? '0 : pc_q + addr_t'(1);
        ST_X1: begin
          if (!legal) begin
            fault_q <= 1'b1;
          end else begin
            case (op)
              OP_SWAP: begin
                a_q <= b_q;
                b_q <= a_q;
              end
              OP_CLEAR: a_q  <= '0;
              OP_JUMP:  pc_q <= op_addr;
              default:  if (mem_op) mar_q <= op_addr;
            endcase
          end
        end
        ST_X2: mdr_q <= (op == OP_STORE) ? a_q : mem_rdata;
        ST_X3: begin
          if (div_zero) begin
            fault_q <= 1'b1;
          end else if (op != OP_STORE) begin
            a_q <= alu_a;
            b_q <= alu_b;
            if (alu_ovf) ovf_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign halted   = (step == ST_HALT);
  assign fault    = fault_q;
  assign overflow = ovf_q;
  assign acc_out  = a_q;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        halted,
  input logic        fault,
  input logic        overflow,
  input logic signed [VAL_W-1:0] acc_out,
  input logic        mem_we,
  input logic [ADDR_W-1:0] pc_q,
  input logic        fault_evt
);
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  p_halt_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(acc_out));

  p_acc_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_out <= DIGIT_LIMIT) && (acc_out >= -DIGIT_LIMIT));

  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_fault_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (halted && fault));

  p_fault_only_halted_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> halted);

  p_we_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_pc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q < ADDR_W'(MEM_WORDS));
endmodule

bind acc_cpu acc_cpu_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .halted   (halted),
  .fault    (fault),
  .overflow (overflow),
  .acc_out  (acc_out),
  .mem_we   (mem_we),
  .pc_q     (pc_q),
  .fault_evt(fault_evt)
);

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] mem_addr;
  logic signed [17:0] mem_wdata, mem_rdata;
  logic mem_we, halted, fault, overflow;
  logic signed [17:0] acc_out;

  logic signed [17:0] mem [0:999];
  int vectors = 0;
  int miscompares = 0;
  int total_cycles = 0;
  int we_count = 0;

  always #2 clk = ~clk;

  acc_cpu u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted), .fault(fault),
    .overflow(overflow), .acc_out(acc_out)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) if (rst_n && mem_we) we_count++;

  always @(posedge clk) begin
    total_cycles++;
    if (total_cycles == 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", total_cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1000; i++) mem[i] = '0;
  endtask

  // Hold reset two clocks, release, then count clocks until stopped.
  task automatic run(output int cyc);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    we_count = 0;
    rst_n = 1'b1;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (halted || cyc >= 3000) break;
    end
  endtask

  task automatic t_reset();
    clear_mem();
    mem[0] = 18'sd99000;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 acc", int'(acc_out), 0);
    check("R1 halted", int'(halted), 0);
    check("R1 fault", int'(fault), 0);
    check("R1 overflow", int'(overflow), 0);
    check("R1 we", int'(mem_we), 0);
    check("R1 first address", int'(mem_addr), 0);
  endtask

  task automatic t_timing();
    int c;
    clear_mem();
    mem[0] = 18'sd1005; mem[1] = 18'sd99000; mem[5] = 18'sd4800;
    run(c);
    check("R2 load+stop clocks", c, 12);
    check("R3 load value", int'(acc_out), 4800);
    clear_mem();
    mem[0] = 18'sd30003; mem[3] = 18'sd99000;
    run(c);
    check("R2 jump+stop clocks", c, 10);
    clear_mem();
    mem[0] = 18'sd99000;
    run(c);
    check("R9 stop alone clocks", c, 5);
    check("R9 no fault on stop", int'(fault), 0);
  endtask

  task automatic t_example();
    int c;
    clear_mem();
    mem[0] = 18'sd1005; mem[1] = 18'sd20004; mem[2] = 18'sd2006;
    mem[3] = 18'sd30007; mem[4] = 18'sd921; mem[5] = 18'sd4800;
    mem[6] = 18'sd807; mem[7] = 18'sd99000;
    run(c);
    check("R3 stored sum", int'(mem[6]), 5721);
    check("R8 jump path clocks", c, 31);
    check("R11 one write per store", we_count, 1);
    check("R4 no overflow", int'(overflow), 0);
  endtask

  task automatic t_addsub();
    int c;
    clear_mem();
    mem[0] = 18'sd1010; mem[1] = 18'sd20011; mem[2] = 18'sd99000;
    mem[10] = 18'sd99990; mem[11] = 18'sd20;
    run(c);
    check("R4 add wrap", int'(acc_out), 10);
    check("R4 add overflow", int'(overflow), 1);
    clear_mem();
    mem[0] = 18'sd1010; mem[1] = 18'sd21011; mem[2] = 18'sd99000;
    mem[10] = -18'sd5; mem[11] = 18'sd99999;
    run(c);
    check("R4 sub wrap negative", int'(acc_out), -4);
    check("R4 sub overflow", int'(overflow), 1);
    clear_mem();
    mem[0] = 18'sd1010; mem[1] = 18'sd21011; mem[2] = 18'sd99000;
    mem[10] = 18'sd123; mem[11] = 18'sd456;
    run(c);
    check("R4 sub in range", int'(acc_out), -333);
    check("R4 overflow cleared by reset", int'(overflow), 0);
  endtask

  task automatic t_mul();
    int c;
    clear_mem();
    mem[0] = 18'sd1010; mem[1] = 18'sd22011; mem[2] = 18'sd2020;
    mem[3] = 18'sd3000; mem[4] = 18'sd2021; mem[5] = 18'sd99000;
    mem[10] = 18'sd12345; mem[11] = 18'sd67890;
    run(c);
    check("R5 product high", int'(mem[20]), 8381);
    check("R5 product low", int'(mem[21]), 2050);
    check("R11 two stores", we_count, 2);
    mem[10] = -18'sd300; mem[11] = 18'sd400; mem[20] = '0; mem[21] = '0;
    run(c);
    check("R5 negative high", int'(mem[20]), -1);
    check("R5 negative low", int'(mem[21]), -20000);
  endtask

  task automatic div_prog(input int hi, input int lo, input int dv);
    clear_mem();
    mem[0] = 18'sd1011; mem[1] = 18'sd3000; mem[2] = 18'sd1010;
    mem[3] = 18'sd23012; mem[4] = 18'sd2020; mem[5] = 18'sd3000;
    mem[6] = 18'sd2021; mem[7] = 18'sd99000;
    mem[10] = 18'(hi); mem[11] = 18'(lo); mem[12] = 18'(dv);
  endtask

  task automatic t_div();
    int c;
    div_prog(3, 45678, 1000);
    run(c);
    check("R6 quotient", int'(mem[20]), 345);
    check("R6 remainder", int'(mem[21]), 678);
    check("R6 no overflow", int'(overflow), 0);
    div_prog(5, 0, 2);
    run(c);
    check("R6 quotient wrap", int'(mem[20]), 50000);
    check("R6 quotient overflow", int'(overflow), 1);
    div_prog(0, -7, 2);
    run(c);
    check("R6 negative quotient", int'(mem[20]), -3);
    check("R6 negative remainder", int'(mem[21]), -1);
  endtask

  task automatic t_swap_clear();
    int c;
    clear_mem();
    mem[0] = 18'sd1010; mem[1] = 18'sd3000; mem[2] = 18'sd1011;
    mem[3] = 18'sd3000; mem[4] = 18'sd4000; mem[5] = 18'sd2020;
    mem[6] = 18'sd3000; mem[7] = 18'sd99000;
    mem[10] = 18'sd111; mem[11] = 18'sd222; mem[20] = 18'sd55;
    run(c);
    check("R7 clear then store", int'(mem[20]), 0);
    check("R7 swap restores", int'(acc_out), 222);
  endtask

  task automatic t_halt();
    int c;
    int bad_we = 0;
    int bad_acc = 0;
    int low_halt = 0;
    clear_mem();
    mem[0] = 18'sd1010; mem[1] = 18'sd99000; mem[2] = 18'sd2030;
    mem[10] = 18'sd555; mem[30] = 18'sd77;
    run(c);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (mem_we) bad_we++;
      if (acc_out != 18'sd555) bad_acc++;
      if (!halted) low_halt++;
    end
    check("R9 no writes after stop", bad_we, 0);
    check("R9 acc frozen", bad_acc, 0);
    check("R9 halted held", low_halt, 0);
    check("R9 later store skipped", int'(mem[30]), 77);
  endtask

  task automatic t_fault();
    int c;
    clear_mem();
    mem[0] = 18'sd1010; mem[1] = 18'sd23011; mem[2] = 18'sd99000;
    mem[10] = 18'sd42; mem[11] = 18'sd0;
    run(c);
    check("R10 div zero clocks", c, 14);
    check("R10 div zero fault", int'(fault), 1);
    check("R10 div zero acc kept", int'(acc_out), 42);
    clear_mem();
    mem[0] = 18'sd5000;
    run(c);
    check("R10 undefined code clocks", c, 5);
    check("R10 undefined code fault", int'(fault), 1);
    clear_mem();
    mem[0] = -18'sd1005;
    run(c);
    check("R10 negative word fault", int'(fault), 1);
    check("R10 negative word acc", int'(acc_out), 0);
  endtask

  initial begin
    clear_mem();
    t_reset();
    t_timing();
    t_example();
    t_addsub();
    t_mul();
    t_div();
    t_swap_clear();
    t_halt();
    t_fault();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule